// File: doc/BRIEF.md
# Dual-Issue Pair Dispatcher

This block sits between instruction fetch and two execution pipes, one integer and one floating-point. Each cycle fetch offers a 64-bit packet with two 32-bit instructions. A decoder supplies a 2-bit class code for each slot, and each pipe reports whether it is stalled. From these the block decides which instructions leave this cycle and puts each one on the instruction bus of its pipe. It tells fetch how many instructions went out and whether the packet was taken. The lower (left) slot is always older than the upper (right) slot.

Issue is in order and asymmetric. A pair leaves together only when the left instruction belongs to the integer pipe and the right one belongs to the floating-point pipe. The right instruction never leaves ahead of the left one. When the left instruction issues but the right one cannot, the right one is moved into a one-entry hold register, and fetch moves on to its next packet. The held instruction issues on its own before any later instruction is looked at. A floating-point memory operation counts as integer-pipe work, so it may pair with a floating-point arithmetic operation. The block flags such a pair because the floating-point register file then sees two accesses in one cycle.

All issue decisions are combinational from the current inputs and the hold register. Only the hold register carries state into the next cycle.

Top module: `pair_dispatch`

## Requirements
- R1: While rst_n is low, slot0_issue, slot1_issue, int_valid and fp_valid are all 0 and the hold register is cleared. On the first cycle with rst_n high, a fetched packet is evaluated directly, with no stale held instruction.
- R2: Class code bit 1 selects the pipe. Codes 2'b00 (integer) and 2'b01 (floating-point memory) go to the integer pipe. Codes 2'b10 and 2'b11 (floating-point arithmetic) go to the floating-point pipe. An issued instruction appears on that pipe's bus with that pipe's valid in the same cycle.
- R3: With no held instruction, fetch_valid high, the left class on the integer pipe, the right class on the floating-point pipe and neither pipe stalled, both slots issue in the same cycle. In that cycle issue_cnt is 2, fetch_adv is 1, the left instruction (fetch_word[31:0]) goes to int_insn and the right one (fetch_word[63:32]) to fp_insn.
- R4: The right slot issues only in a cycle in which the left slot issues. If the pipe of the left instruction is stalled, neither slot issues, issue_cnt is 0 and fetch_adv is 0.
- R5: If the two classes do not form the integer-left, floating-point-right pattern, only the left instruction issues, with issue_cnt 1 and fetch_adv 1. The right instruction is held and becomes the only issue candidate of the next cycle.
- R6: If the left instruction of a legal pair issues but the floating-point pipe is stalled, the right instruction is held in the same way as in R5.
- R7: While an instruction is held, fetch_adv is 0 and slot1_issue is 0. The held instruction issues through slot0 to its own pipe as soon as that pipe is not stalled, and stays held unchanged while it is stalled.
- R8: With no held instruction and fetch_valid low, nothing issues and fetch_adv is 0.
- R9: fp_port_pair is 1 exactly when both slots issue and the left class is 2'b01 (floating-point memory paired with floating-point arithmetic).
- R10: A pipe never receives an instruction in a cycle in which its stall input is high, and issue_cnt equals the number of pipes receiving an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Packet on fetch_word is valid |
| fetch_word | input | 64 | Two instructions, left (older) in bits 31:0, right in bits 63:32 |
| cls_lo | input | 2 | Class code of the left instruction |
| cls_hi | input | 2 | Class code of the right instruction |
| int_stall | input | 1 | Integer pipe cannot accept an instruction |
| fp_stall | input | 1 | Floating-point pipe cannot accept an instruction |
| slot0_issue | output | 1 | First candidate (held or left) issues |
| slot1_issue | output | 1 | Right instruction issues alongside the first |
| issue_cnt | output | 2 | Number of instructions issued this cycle |
| fetch_adv | output | 1 | Packet taken; fetch may present the next one |
| int_valid | output | 1 | int_insn carries an issued instruction |
| int_insn | output | 32 | Instruction to the integer pipe |
| fp_valid | output | 1 | fp_insn carries an issued instruction |
| fp_insn | output | 32 | Instruction to the floating-point pipe |
| fp_port_pair | output | 1 | Paired issue needs two floating-point register file accesses |

## Verification
Every issue enable, the pipe buses, issue_cnt, fetch_adv and fp_port_pair follow the inputs and the hold register in the same cycle. The bench therefore drives each input set just after a falling edge and samples one nanosecond later, before the next rising edge. A held instruction becomes visible exactly one rising edge after the cycle that parked it. Each scenario checks that next cycle at the following falling-edge window, and checks the cycle after it again to confirm the packet order. The reset checks use the same windows: one while reset is low, then the first window after release.

// File: rtl/pair_dispatch_pkg.sv
package pair_dispatch_pkg;

  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT   = 2'b00,
    CLS_FPMEM = 2'b01,
    CLS_FPOP  = 2'b10,
    CLS_FPOP2 = 2'b11
  } insn_cls_e;

  // bit 1 of the class picks the floating-point pipe
  function automatic logic goes_fp(input logic [CLS_W-1:0] c);
    return c[1];
  endfunction

  // integer-pipe work that touches the floating-point register file
  function automatic logic touches_fprf(input logic [CLS_W-1:0] c);
    return (c == CLS_FPMEM);
  endfunction

  // legal pair shape: older on integer pipe, younger on fp pipe
  function automatic logic pair_shape_ok(input logic [CLS_W-1:0] left,
                                         input logic [CLS_W-1:0] right);
    return !goes_fp(left) && goes_fp(right);
  endfunction

  function automatic logic [1:0] n_issued(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction

endpackage

// File: rtl/pd_select.sv
module pd_select
  import pair_dispatch_pkg::*;
(
  input  logic             en,
  input  logic             hold_vld,
  input  logic [CLS_W-1:0] hold_cls,
  input  logic             fetch_valid,
  input  logic [CLS_W-1:0] cls_lo,
  input  logic [CLS_W-1:0] cls_hi,
  input  logic             int_stall,
  input  logic             fp_stall,
  output logic             first_go,
  output logic             second_go,
  output logic             take_pkt,
  output logic             park_hi
);

  logic [CLS_W-1:0] first_cls;
  logic             first_present;
  logic             first_blocked;

  always_comb begin
    first_cls     = hold_vld ? hold_cls : cls_lo;
    first_present = hold_vld || fetch_valid;
    first_blocked = goes_fp(first_cls) ? fp_stall : int_stall;
    first_go      = en && first_present && !first_blocked;
    second_go     = first_go && !hold_vld && pair_shape_ok(cls_lo, cls_hi) && !fp_stall;
    take_pkt      = first_go && !hold_vld;
    park_hi       = take_pkt && !second_go;
  end

endmodule

// File: rtl/pd_hold.sv
module pd_hold
  import pair_dispatch_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drain,
  input  logic [INSN_W-1:0] insn_in,
  input  logic [CLS_W-1:0]  cls_in,
  output logic              vld,
  output logic [INSN_W-1:0] insn,
  output logic [CLS_W-1:0]  cls
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      insn <= '0;
      cls  <= '0;
    end else if (load) begin
      vld  <= 1'b1;
      insn <= insn_in;
      cls  <= cls_in;
    end else if (drain) begin
      vld  <= 1'b0;
    end
  end

endmodule

// File: rtl/pd_route.sv
module pd_route
  import pair_dispatch_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic              first_go,
  input  logic              second_go,
  input  logic [INSN_W-1:0] first_insn,
  input  logic [CLS_W-1:0]  first_cls,
  input  logic [INSN_W-1:0] second_insn,
  output logic              int_valid,
  output logic [INSN_W-1:0] int_insn,
  output logic              fp_valid,
  output logic [INSN_W-1:0] fp_insn,
  output logic              fp_port_pair
);

  logic first_to_fp;

  always_comb begin
    first_to_fp  = goes_fp(first_cls);
    int_valid    = first_go && !first_to_fp;
    int_insn     = int_valid ? first_insn : '0;
    fp_valid     = second_go || (first_go && first_to_fp);
    if (second_go)
      fp_insn = second_insn;
    else if (first_go && first_to_fp)
      fp_insn = first_insn;
    else
      fp_insn = '0;
    fp_port_pair = second_go && touches_fprf(first_cls);
  end

endmodule

// File: rtl/pair_dispatch.sv
module pair_dispatch
  import pair_dispatch_pkg::*;
#(
  parameter int INSN_W  = 32,
  localparam int NSLOT   = 2,
  localparam int FETCH_W = NSLOT * INSN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic [FETCH_W-1:0] fetch_word,
  input  logic [CLS_W-1:0]   cls_lo,
  input  logic [CLS_W-1:0]   cls_hi,
  input  logic               int_stall,
  input  logic               fp_stall,
  output logic               slot0_issue,
  output logic               slot1_issue,
  output logic [1:0]         issue_cnt,
  output logic               fetch_adv,
  output logic               int_valid,
  output logic [INSN_W-1:0]  int_insn,
  output logic               fp_valid,
  output logic [INSN_W-1:0]  fp_insn,
  output logic               fp_port_pair
);

  logic [INSN_W-1:0] slot_insn [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_split
    assign slot_insn[g] = fetch_word[g*INSN_W +: INSN_W];
  end

  // named internal events for the checker
  logic              hold_vld;
  logic [INSN_W-1:0] hold_insn;
  logic [CLS_W-1:0]  hold_cls;
  logic              park_hi;
  logic              drain_hold;
  logic [INSN_W-1:0] first_insn;
  logic [CLS_W-1:0]  first_cls;

  pd_select u_sel (
    .en          (rst_n),
    .hold_vld    (hold_vld),
    .hold_cls    (hold_cls),
    .fetch_valid (fetch_valid),
    .cls_lo      (cls_lo),
    .cls_hi      (cls_hi),
    .int_stall   (int_stall),
    .fp_stall    (fp_stall),
    .first_go    (slot0_issue),
    .second_go   (slot1_issue),
    .take_pkt    (fetch_adv),
    .park_hi     (park_hi)
  );

  assign drain_hold = hold_vld && slot0_issue;

  pd_hold #(.INSN_W(INSN_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (park_hi),
    .drain   (drain_hold),
    .insn_in (slot_insn[1]),
    .cls_in  (cls_hi),
    .vld     (hold_vld),
    .insn    (hold_insn),
    .cls     (hold_cls)
  );

  assign first_insn = hold_vld ? hold_insn : slot_insn[0];
  assign first_cls  = hold_vld ? hold_cls  : cls_lo;

  pd_route #(.INSN_W(INSN_W)) u_route (
    .first_go     (slot0_issue),
    .second_go    (slot1_issue),
    .first_insn   (first_insn),
    .first_cls    (first_cls),
    .second_insn  (slot_insn[1]),
    .int_valid    (int_valid),
    .int_insn     (int_insn),
    .fp_valid     (fp_valid),
    .fp_insn      (fp_insn),
    .fp_port_pair (fp_port_pair)
  );

  assign issue_cnt = n_issued(slot0_issue, slot1_issue);

endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int INSN_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [INSN_W-1:0] hi_word,
  input logic [1:0]        cls_lo,
  input logic [1:0]        cls_hi,
  input logic              int_stall,
  input logic              fp_stall,
  input logic              slot0_issue,
  input logic              slot1_issue,
  input logic [1:0]        issue_cnt,
  input logic              fetch_adv,
  input logic              int_valid,
  input logic              fp_valid,
  input logic              hold_vld,
  input logic [INSN_W-1:0] hold_insn
);

  always_comb begin
    if (!rst_n)
      assert_reset_quiet_R1: assert (!slot0_issue && !slot1_issue && !int_valid && !fp_valid);
  end

  assert_right_after_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot1_issue |-> slot0_issue);

  assert_pair_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot1_issue |-> (int_valid && fp_valid && !cls_lo[1] && cls_hi[1]));

  assert_left_stall_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_vld && fetch_valid && (cls_lo[1] ? fp_stall : int_stall)) |-> (issue_cnt == 2'd0 && !fetch_adv));

  assert_park_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_adv && !slot1_issue) |=> (hold_vld && hold_insn == $past(hi_word)));

  assert_hold_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld |-> (!fetch_adv && !slot1_issue));

  assert_hold_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && !slot0_issue) |=> (hold_vld && $stable(hold_insn)));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_vld && !fetch_valid) |-> (issue_cnt == 2'd0 && !fetch_adv));

  assert_int_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int_stall |-> !int_valid);

  assert_fp_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fp_stall |-> !fp_valid);

  assert_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_cnt == 2'($countones({int_valid, fp_valid})));

endmodule

bind pair_dispatch pd_checker #(.INSN_W(INSN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .hi_word     (fetch_word[FETCH_W-1:INSN_W]),
  .cls_lo      (cls_lo),
  .cls_hi      (cls_hi),
  .int_stall   (int_stall),
  .fp_stall    (fp_stall),
  .slot0_issue (slot0_issue),
  .slot1_issue (slot1_issue),
  .issue_cnt   (issue_cnt),
  .fetch_adv   (fetch_adv),
  .int_valid   (int_valid),
  .fp_valid    (fp_valid),
  .hold_vld    (hold_vld),
  .hold_insn   (hold_insn)
);

// File: tb/pair_dispatch_test.sv
`timescale 1ns/100ps
module pair_dispatch_test;

  localparam real HALF = 2.5;
  localparam logic [1:0] C_INT = 2'b00, C_FMEM = 2'b01, C_FOP = 2'b10, C_FOP2 = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [63:0] fetch_word = '0;
  logic [1:0]  cls_lo = '0, cls_hi = '0;
  logic        int_stall = 1'b0, fp_stall = 1'b0;
  logic        slot0_issue, slot1_issue, fetch_adv, int_valid, fp_valid, fp_port_pair;
  logic [1:0]  issue_cnt;
  logic [31:0] int_insn, fp_insn;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(HALF) clk = ~clk;

  pair_dispatch uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .cls_lo(cls_lo), .cls_hi(cls_hi), .int_stall(int_stall), .fp_stall(fp_stall),
    .slot0_issue(slot0_issue), .slot1_issue(slot1_issue), .issue_cnt(issue_cnt),
    .fetch_adv(fetch_adv), .int_valid(int_valid), .int_insn(int_insn),
    .fp_valid(fp_valid), .fp_insn(fp_insn), .fp_port_pair(fp_port_pair)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one cycle's inputs after a falling edge, then settle
  task automatic put(input logic v, input logic [31:0] lo, input logic [1:0] cl,
                     input logic [31:0] hi, input logic [1:0] ch,
                     input logic ist, input logic fst);
    @(negedge clk);
    fetch_valid = v;
    fetch_word  = {hi, lo};
    cls_lo      = cl;
    cls_hi      = ch;
    int_stall   = ist;
    fp_stall    = fst;
    #1;
  endtask

  // expected: slot0, slot1, count, adv, int valid/insn, fp valid/insn, port pair
  task automatic expect_out(input string req, input logic s0, input logic s1, input logic [1:0] cnt,
                            input logic adv, input logic iv, input logic [31:0] ii,
                            input logic fv, input logic [31:0] fi, input logic pp);
    chk(req, "slot0_issue", 32'(slot0_issue), 32'(s0));
    chk(req, "slot1_issue", 32'(slot1_issue), 32'(s1));
    chk(req, "issue_cnt",   32'(issue_cnt),   32'(cnt));
    chk(req, "fetch_adv",   32'(fetch_adv),   32'(adv));
    chk(req, "int_valid",   32'(int_valid),   32'(iv));
    if (iv) chk(req, "int_insn", int_insn, ii);
    chk(req, "fp_valid",    32'(fp_valid),    32'(fv));
    if (fv) chk(req, "fp_insn", fp_insn, fi);
    chk(req, "fp_port_pair", 32'(fp_port_pair), 32'(pp));
  endtask

  task automatic t_reset;
    put(1'b1, 32'hA000_0001, C_INT, 32'hB000_0001, C_FOP, 1'b0, 1'b0);
    expect_out("R1", 0, 0, 2'd0, 0, 0, '0, 0, '0, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    expect_out("R1", 1, 1, 2'd2, 1, 1, 32'hA000_0001, 1, 32'hB000_0001, 0);
  endtask

  task automatic t_pair;
    put(1'b1, 32'hA000_0002, C_INT, 32'hB000_0002, C_FOP2, 1'b0, 1'b0);
    expect_out("R3", 1, 1, 2'd2, 1, 1, 32'hA000_0002, 1, 32'hB000_0002, 0);
  endtask

  task automatic t_fp_mem_pair;
    put(1'b1, 32'hA000_0003, C_FMEM, 32'hB000_0003, C_FOP, 1'b0, 1'b0);
    expect_out("R9", 1, 1, 2'd2, 1, 1, 32'hA000_0003, 1, 32'hB000_0003, 1);
    put(1'b1, 32'hA000_0004, C_FMEM, 32'hB000_0004, C_FOP2, 1'b0, 1'b0);
    expect_out("R9", 1, 1, 2'd2, 1, 1, 32'hA000_0004, 1, 32'hB000_0004, 1);
  endtask

  task automatic t_left_stall;
    put(1'b1, 32'hA000_0005, C_INT, 32'hB000_0005, C_FOP, 1'b1, 1'b0);
    expect_out("R4", 0, 0, 2'd0, 0, 0, '0, 0, '0, 0);
    put(1'b1, 32'hA000_0006, C_FOP, 32'hB000_0006, C_FOP, 1'b0, 1'b1);
    expect_out("R4", 0, 0, 2'd0, 0, 0, '0, 0, '0, 0);
  endtask

  task automatic t_right_stall;
    put(1'b1, 32'hA000_0007, C_INT, 32'hB000_0007, C_FOP, 1'b0, 1'b1);
    expect_out("R6", 1, 0, 2'd1, 1, 1, 32'hA000_0007, 0, '0, 0);
    put(1'b1, 32'hC000_0007, C_INT, 32'hD000_0007, C_FOP, 1'b0, 1'b0);
    expect_out("R7", 1, 0, 2'd1, 0, 0, '0, 1, 32'hB000_0007, 0);
    put(1'b1, 32'hC000_0007, C_INT, 32'hD000_0007, C_FOP, 1'b0, 1'b0);
    expect_out("R7", 1, 1, 2'd2, 1, 1, 32'hC000_0007, 1, 32'hD000_0007, 0);
  endtask

  task automatic t_mismatch;
    put(1'b1, 32'hA000_0008, C_INT, 32'hB000_0008, C_INT, 1'b0, 1'b0);
    expect_out("R5", 1, 0, 2'd1, 1, 1, 32'hA000_0008, 0, '0, 0);
    put(1'b1, 32'hC000_0008, C_INT, 32'hD000_0008, C_FOP, 1'b0, 1'b0);
    expect_out("R5", 1, 0, 2'd1, 0, 1, 32'hB000_0008, 0, '0, 0);
    put(1'b1, 32'hA000_0009, C_FOP, 32'hB000_0009, C_INT, 1'b0, 1'b0);
    expect_out("R2", 1, 0, 2'd1, 1, 0, '0, 1, 32'hA000_0009, 0);
    put(1'b1, 32'hC000_0009, C_INT, 32'hD000_0009, C_FOP, 1'b1, 1'b0);
    expect_out("R7", 0, 0, 2'd0, 0, 0, '0, 0, '0, 0);
    put(1'b1, 32'hC000_0009, C_INT, 32'hD000_0009, C_FOP, 1'b1, 1'b0);
    expect_out("R7", 0, 0, 2'd0, 0, 0, '0, 0, '0, 0);
    put(1'b1, 32'hC000_0009, C_INT, 32'hD000_0009, C_FOP, 1'b0, 1'b0);
    expect_out("R7", 1, 0, 2'd1, 0, 1, 32'hB000_0009, 0, '0, 0);
    put(1'b1, 32'hA000_000A, C_FOP2, 32'hB000_000A, C_FOP, 1'b0, 1'b0);
    expect_out("R5", 1, 0, 2'd1, 1, 0, '0, 1, 32'hA000_000A, 0);
    put(1'b1, 32'hC000_000A, C_INT, 32'hD000_000A, C_FOP, 1'b0, 1'b0);
    expect_out("R2", 1, 0, 2'd1, 0, 0, '0, 1, 32'hB000_000A, 0);
  endtask

  task automatic t_idle;
    put(1'b0, 32'hA000_000B, C_INT, 32'hB000_000B, C_FOP, 1'b0, 1'b0);
    expect_out("R8", 0, 0, 2'd0, 0, 0, '0, 0, '0, 0);
  endtask

  task automatic t_reset_drops_hold;
    put(1'b1, 32'hA000_000C, C_INT, 32'hB000_000C, C_INT, 1'b0, 1'b0);
    expect_out("R5", 1, 0, 2'd1, 1, 1, 32'hA000_000C, 0, '0, 0);
    @(negedge clk); rst_n = 1'b0; fetch_valid = 1'b0; #1;
    expect_out("R1", 0, 0, 2'd0, 0, 0, '0, 0, '0, 0);
    @(negedge clk); rst_n = 1'b1;
    fetch_valid = 1'b1; fetch_word = {32'hF000_000C, 32'hE000_000C};
    cls_lo = C_INT; cls_hi = C_FOP; #1;
    expect_out("R1", 1, 1, 2'd2, 1, 1, 32'hE000_000C, 1, 32'hF000_000C, 0);
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_pair;
    t_fp_mem_pair;
    t_left_stall;
    t_right_stall;
    t_mismatch;
    t_idle;
    t_reset_drops_hold;
    @(negedge clk);
    finish_up;
  end

  initial begin
    #(HALF * 2 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up;
  end

endmodule